// File: doc/BRIEF.md
# Mixed-direction parallel I/O port register bank

This block holds the software-visible registers of six small parallel ports and two address-extension bank registers. A processor reaches them through a simple byte-wide register bus: one address, a write strobe, write data, and a read data path that is combinational from the address. Each port has a fixed role for every bit. Some bits are driven from an output latch, some are sampled live from the pins, and some can be switched by a direction register. A read merges latched bits and live pin bits through masks fixed for each port.

The pin side consists of one input vector per readable port and, for each drivable port, an output value and an output-enable mask. Output values change on the clock edge that takes a write. Output enables are decoded combinationally from the direction registers, so they follow a direction write in the same edge.

The two bank registers keep only the low nibble of a write. They read back with the upper nibble forced to ones.

Top module: `port_bank_io`

## Requirements
- R1: Asynchronous active-low reset clears every latch, direction register and bank register. After reset, address 1 reads 0x00, addresses 2, 6 and 8 read 0x00, addresses 9 and 10 read 0xF0, `p4_oe` is 0xF, `p6_oe` and `p7_oe` are 0x0, and `p8_oe` is 1.
- R2: Port A (address 0) keeps only bits 0x6C of a write in its latch and drives them on `p3_out`, with `p3_oe` fixed at 0x6C. A read returns (latch AND 0x6C) OR (`p3_in` AND 0x93).
- R3: Port B data (address 1) keeps only the low nibble of a write. A read returns the latch AND 0x0F. `p4_out` shows the new latch from the clock edge that takes the write.
- R4: Port B direction (address 2) stores a full byte that reads back unchanged. `p4_oe` bit i is 1 exactly when direction bit i (i = 0..3) is 0.
- R5: Port C (address 3) reads `p5_in` AND 0x3F. A write to address 3 changes no output and no register.
- R6: Ports D (address 4) and E (address 5) store a full byte. A read returns latch bits 7:4 over pin bits 3:0. `p6_out` and `p7_out` carry latch bits 3:0. The shared direction register (address 6) sets `p6_oe` from its bits 3:0 and `p7_oe` from its bits 7:4, where a 1 means drive.
- R7: Port F data (address 7) keeps the low nibble of a write. A read returns (latch AND 0x08) OR (`p8_in` AND 0x07). `p8_out` is latch bit 3. `p8_oe` is 1 exactly when bit 3 of the direction register (address 8) is 0.
- R8: Bank registers X (address 9) and Y (address 10) store write bits 3:0, read back as 0xF0 OR the stored nibble, and appear on `bank_x` and `bank_y`.
- R9: Addresses 11 to 15 read 0x00, and a write to them changes no register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| p3_in | input | 8 | Port A pin levels |
| p5_in | input | 8 | Port C pin levels |
| p6_in | input | 8 | Port D pin levels |
| p7_in | input | 8 | Port E pin levels |
| p8_in | input | 8 | Port F pin levels |
| p3_out | output | 8 | Port A drive values |
| p3_oe | output | 8 | Port A output enables |
| p4_out | output | 4 | Port B drive values |
| p4_oe | output | 4 | Port B output enables |
| p6_out | output | 4 | Port D drive values |
| p6_oe | output | 4 | Port D output enables |
| p7_out | output | 4 | Port E drive values |
| p7_oe | output | 4 | Port E output enables |
| p8_out | output | 1 | Port F bit 3 drive value |
| p8_oe | output | 1 | Port F bit 3 output enable |
| bank_x | output | 4 | Bank X value |
| bank_y | output | 4 | Bank Y value |

## Verification
On every cycle, the assertions check the write-to-output timing of ports A and B, that writes to port C or to unused addresses leave every output stable, that enables move only after a direction write, and that bank reads carry a forced-high upper nibble. Only the bench's scenarios can show the merge of latch and live pin bits for each port's masks, the reset values, the full readback of direction registers, and the zero read of unused addresses.

// File: rtl/port_bank_io.sv
module port_bank_io #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [7:0]    p3_in,
  input  logic [7:0]    p5_in,
  input  logic [7:0]    p6_in,
  input  logic [7:0]    p7_in,
  input  logic [7:0]    p8_in,
  output logic [7:0]    p3_out,
  output logic [7:0]    p3_oe,
  output logic [3:0]    p4_out,
  output logic [3:0]    p4_oe,
  output logic [3:0]    p6_out,
  output logic [3:0]    p6_oe,
  output logic [3:0]    p7_out,
  output logic [3:0]    p7_oe,
  output logic          p8_out,
  output logic          p8_oe,
  output logic [3:0]    bank_x,
  output logic [3:0]    bank_y
);
  localparam logic [AW-1:0] A_P3   = AW'(0);
  localparam logic [AW-1:0] A_P4   = AW'(1);
  localparam logic [AW-1:0] A_P4D  = AW'(2);
  localparam logic [AW-1:0] A_P5   = AW'(3);
  localparam logic [AW-1:0] A_P6   = AW'(4);
  localparam logic [AW-1:0] A_P7   = AW'(5);
  localparam logic [AW-1:0] A_P67D = AW'(6);
  localparam logic [AW-1:0] A_P8   = AW'(7);
  localparam logic [AW-1:0] A_P8D  = AW'(8);
  localparam logic [AW-1:0] A_BX   = AW'(9);
  localparam logic [AW-1:0] A_BY   = AW'(10);

  localparam logic [7:0] P3_LAT = 8'h6C;
  localparam logic [7:0] P3_PIN = 8'h93;
  localparam logic [7:0] P5_PIN = 8'h3F;
  localparam logic [7:0] P8_LAT = 8'h08;
  localparam logic [7:0] P8_PIN = 8'h07;

  logic [7:0] lat3, lat6, lat7, dir4, dir67, dir8;
  logic [3:0] lat4, lat8, bx, by;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat3 <= '0; lat4 <= '0; lat6 <= '0; lat7 <= '0; lat8 <= '0;
      dir4 <= '0; dir67 <= '0; dir8 <= '0; bx <= '0; by <= '0;
    end else if (wr_en) begin
      case (addr)
        A_P3:    lat3  <= wdata & P3_LAT;
        A_P4:    lat4  <= wdata[3:0];
        A_P4D:   dir4  <= wdata;
        A_P6:    lat6  <= wdata;
        A_P7:    lat7  <= wdata;
        A_P67D:  dir67 <= wdata;
        A_P8:    lat8  <= wdata[3:0];
        A_P8D:   dir8  <= wdata;
        A_BX:    bx    <= wdata[3:0];
        A_BY:    by    <= wdata[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_P3:    rdata = (lat3 & P3_LAT) | (p3_in & P3_PIN);
      A_P4:    rdata = {4'h0, lat4};
      A_P4D:   rdata = dir4;
      A_P5:    rdata = p5_in & P5_PIN;
      A_P6:    rdata = {lat6[7:4], p6_in[3:0]};
      A_P7:    rdata = {lat7[7:4], p7_in[3:0]};
      A_P67D:  rdata = dir67;
      A_P8:    rdata = ({4'h0, lat8} & P8_LAT) | (p8_in & P8_PIN);
      A_P8D:   rdata = dir8;
      A_BX:    rdata = {4'hF, bx};
      A_BY:    rdata = {4'hF, by};
      default: rdata = 8'h00;
    endcase
  end

  assign p3_out = lat3;
  assign p3_oe  = P3_LAT;
  assign p4_out = lat4;
  assign p4_oe  = ~dir4[3:0];
  assign p6_out = lat6[3:0];
  assign p6_oe  = dir67[3:0];
  assign p7_out = lat7[3:0];
  assign p7_oe  = dir67[7:4];
  assign p8_out = lat8[3];
  assign p8_oe  = ~dir8[3];
  assign bank_x = bx;
  assign bank_y = by;

  a_r2_p3_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_P3) |=> (p3_out == ($past(wdata) & 8'h6C)));

  a_r3_p4_out_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_P4) |=> (p4_out == $past(wdata[3:0])));

  a_r4_p4_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_P4D) |=> $stable(p4_oe));

  a_r5_p5_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_P5) |=> ($stable(p3_out) && $stable(p4_out) && $stable(p6_out)
      && $stable(p7_out) && $stable(p8_out) && $stable(p4_oe) && $stable(p6_oe)
      && $stable(p7_oe) && $stable(p8_oe) && $stable(bank_x) && $stable(bank_y)));

  a_r8_bank_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_BX || addr == A_BY) |-> (rdata[7:4] == 4'hF));

  a_r9_unused_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > A_BY) |=> ($stable(p3_out) && $stable(p4_out) && $stable(p6_out)
      && $stable(p7_out) && $stable(p8_out) && $stable(p4_oe) && $stable(p6_oe)
      && $stable(p7_oe) && $stable(p8_oe) && $stable(bank_x) && $stable(bank_y)));
endmodule

// File: tb/sim_port_bank_io.sv
module sim_port_bank_io;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] p3_in = '0, p5_in = '0, p6_in = '0, p7_in = '0, p8_in = '0;
  logic [7:0] p3_out, p3_oe;
  logic [3:0] p4_out, p4_oe, p6_out, p6_oe, p7_out, p7_oe, bank_x, bank_y;
  logic p8_out, p8_oe;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  port_bank_io #(.AW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .p3_in(p3_in), .p5_in(p5_in), .p6_in(p6_in), .p7_in(p7_in), .p8_in(p8_in),
    .p3_out(p3_out), .p3_oe(p3_oe), .p4_out(p4_out), .p4_oe(p4_oe),
    .p6_out(p6_out), .p6_oe(p6_oe), .p7_out(p7_out), .p7_oe(p7_oe),
    .p8_out(p8_out), .p8_oe(p8_oe), .bank_x(bank_x), .bank_y(bank_y)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check_reset_state(input string tag);
    logic [7:0] v;
    rd(4'd1, v);  chk({tag, " p4 data"}, v, 8'h00);
    rd(4'd2, v);  chk({tag, " p4 dir"}, v, 8'h00);
    rd(4'd6, v);  chk({tag, " p67 dir"}, v, 8'h00);
    rd(4'd8, v);  chk({tag, " p8 dir"}, v, 8'h00);
    rd(4'd9, v);  chk({tag, " bank x"}, v, 8'hF0);
    rd(4'd10, v); chk({tag, " bank y"}, v, 8'hF0);
    chk({tag, " p4_oe"}, p4_oe, 4'hF);
    chk({tag, " p6_oe"}, p6_oe, 4'h0);
    chk({tag, " p7_oe"}, p7_oe, 4'h0);
    chk({tag, " p8_oe"}, p8_oe, 1'b1);
    chk({tag, " p3_out"}, p3_out, 8'h00);
  endtask

  task automatic t_port_a;
    logic [7:0] v;
    wr(4'd0, 8'hFF);
    chk("R2 p3_out", p3_out, 8'h6C);
    chk("R2 p3_oe", p3_oe, 8'h6C);
    p3_in = 8'hFF; rd(4'd0, v); chk("R2 read all ones", v, 8'hFF);
    p3_in = 8'h00; rd(4'd0, v); chk("R2 read latch only", v, 8'h6C);
    wr(4'd0, 8'h00);
    p3_in = 8'hFF; rd(4'd0, v); chk("R2 read pins only", v, 8'h93);
  endtask

  task automatic t_port_b;
    logic [7:0] v;
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd1; wdata = 8'hA5;
    chk("R3 p4_out before edge", p4_out, 4'h0);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R3 p4_out after edge", p4_out, 4'h5);
    rd(4'd1, v); chk("R3 read masked", v, 8'h05);
    wr(4'd2, 8'hCA);
    chk("R4 p4_oe", p4_oe, 4'h5);
    rd(4'd2, v); chk("R4 dir readback", v, 8'hCA);
    wr(4'd2, 8'hF0);
    chk("R4 p4_oe high dir bits", p4_oe, 4'hF);
  endtask

  task automatic t_port_c;
    logic [7:0] v;
    p5_in = 8'hFF; rd(4'd3, v); chk("R5 read", v, 8'h3F);
    p5_in = 8'h2A; rd(4'd3, v); chk("R5 read pattern", v, 8'h2A);
    wr(4'd3, 8'h00);
    rd(4'd3, v); chk("R5 read after write", v, 8'h2A);
    chk("R5 p3_out unchanged", p3_out, 8'h00);
    chk("R5 p4_out unchanged", p4_out, 4'h5);
  endtask

  task automatic t_ports_de;
    logic [7:0] v;
    wr(4'd4, 8'hB7);
    p6_in = 8'hFC; rd(4'd4, v); chk("R6 p6 read", v, 8'hBC);
    chk("R6 p6_out", p6_out, 4'h7);
    wr(4'd5, 8'h3E);
    p7_in = 8'hF1; rd(4'd5, v); chk("R6 p7 read", v, 8'h31);
    chk("R6 p7_out", p7_out, 4'hE);
    wr(4'd6, 8'h5A);
    chk("R6 p6_oe", p6_oe, 4'hA);
    chk("R6 p7_oe", p7_oe, 4'h5);
    rd(4'd6, v); chk("R6 dir readback", v, 8'h5A);
  endtask

  task automatic t_port_f;
    logic [7:0] v;
    wr(4'd7, 8'hFF);
    p8_in = 8'hFF; rd(4'd7, v); chk("R7 read ones", v, 8'h0F);
    p8_in = 8'h00; rd(4'd7, v); chk("R7 read latch", v, 8'h08);
    chk("R7 p8_out", p8_out, 1'b1);
    wr(4'd7, 8'hF7);
    p8_in = 8'h05; rd(4'd7, v); chk("R7 read pins", v, 8'h05);
    chk("R7 p8_out low", p8_out, 1'b0);
    wr(4'd8, 8'h08); chk("R7 p8_oe off", p8_oe, 1'b0);
    wr(4'd8, 8'hF7); chk("R7 p8_oe on", p8_oe, 1'b1);
  endtask

  task automatic t_banks;
    logic [7:0] v;
    wr(4'd9, 8'h3C);
    rd(4'd9, v); chk("R8 bank x read", v, 8'hFC);
    chk("R8 bank_x", bank_x, 4'hC);
    wr(4'd10, 8'hA5);
    rd(4'd10, v); chk("R8 bank y read", v, 8'hF5);
    chk("R8 bank_y", bank_y, 4'h5);
  endtask

  task automatic t_unused;
    logic [7:0] v;
    for (int a = 11; a < 16; a++) begin
      wr(4'(a), 8'hFF);
      rd(4'(a), v); chk("R9 unused read", v, 8'h00);
    end
    rd(4'd1, v);  chk("R9 p4 intact", v, 8'h05);
    rd(4'd9, v);  chk("R9 bank x intact", v, 8'hFC);
    rd(4'd10, v); chk("R9 bank y intact", v, 8'hF5);
    chk("R9 p8_oe intact", p8_oe, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state("R1 initial");
    t_port_a();
    t_port_b();
    t_port_c();
    t_ports_de();
    t_port_f();
    t_banks();
    t_unused();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_reset_state("R1 mid-run");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule